// File: doc/BRIEF.md
# Queue Barrier Dependency Gate

This block sits beside one command queue of a packet processor and decides whether the next packet may be dispatched. It tracks three queue conditions: open, held by a packet that carried the barrier flag, and held by a barrier packet. A flagged packet holds the queue until the packet in flight reports completion. A barrier packet lists up to `NSIG` dependency signals, each selected by a bit of a slot mask and located by an address field.

While a barrier packet holds the queue, the gate reads every selected signal through a tagged request/response port. It counts the reads still in flight and stores each returned value in its slot. When the round has fully returned and every selected value is zero, the barrier is satisfied and the queue opens. If any selected value is nonzero, the gate waits a programmable number of cycles and reads the whole set again. At the start of each new barrier and each retry round, every stored value is set to 1, so a slot that has not been read can never pass the zero test.

If the queue is unmapped while reads are in flight, the gate opens the queue at once and stops issuing. The responses still outstanding are drained, and their data is thrown away. No new packet is accepted until the last of those responses has returned.

Top module: `bdc_gate`

## Requirements
- R1: Synchronous active-high reset gives q_state 0, pkt_ready 1, and rd_req_valid, all_read, barrier_done and unblock all 0. Reset also clears the outstanding-read count and the discard condition, even when reset arrives while reads are in flight. A barrier dispatched after such a reset completes normally.
- R2: q_state encodes the queue condition as follows: 0 is open, 1 is held by the barrier flag, 2 is held by a barrier packet. A packet that is neither a barrier packet nor flagged is accepted with q_state staying 0 and pkt_ready staying 1.
- R3: A flagged non-barrier packet sets q_state to 1 from the cycle after dispatch, and pkt_ready is 0 during that time. When pkt_done is sampled high, the next cycle shows q_state 0, and unblock is high for exactly that one cycle.
- R4: A barrier packet sets q_state to 2, and it takes precedence over the flag. The gate issues one read per set bit of pkt_dep_mask, in ascending slot order. Each read carries tag = slot index and address = pkt_dep_addr[slot*AW +: AW]. No read is issued for a clear bit.
- R5: A response is accepted only while at least one read is outstanding. A stray response arriving when nothing is outstanding changes neither the count nor any stored value, so the barrier still completes normally afterwards.
- R6: all_read is high for one cycle once every read of the round has been issued and answered. For an empty mask, this happens in the first cycle after dispatch.
- R7: When every selected slot holds zero in the all_read cycle, the next cycle shows q_state 0, and barrier_done and unblock are each high for exactly one cycle.
- R8: When any selected slot is nonzero, rd_req_valid stays 0 for retry_delay+1 cycles after the all_read cycle. The full set of reads is then issued again, and the barrier completes once a later round returns all zeros.
- R9: Unmap while a barrier holds the queue behaves as follows. The next cycle shows q_state 0, no further reads are issued, and neither barrier_done nor unblock pulses. pkt_ready stays 0 until the last outstanding response has been accepted, and becomes 1 in the cycle after it.
- R10: Unmap while the flag holds the queue sets q_state to 0 with no unblock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Next packet is offered for dispatch |
| pkt_ready | output | 1 | Gate allows dispatch this cycle |
| pkt_is_barrier | input | 1 | Offered packet is a barrier packet |
| pkt_flag | input | 1 | Offered packet carries the barrier flag |
| pkt_dep_mask | input | NSIG | Slots of the barrier packet that hold a dependency signal |
| pkt_dep_addr | input | NSIG*AW | Signal address per slot, slot i at bits i*AW upward |
| pkt_done | input | 1 | Packet in flight has completed |
| unmap | input | 1 | Queue is being unmapped |
| retry_delay | input | DLY_W | Idle cycles minus one between read rounds |
| rd_req_valid | output | 1 | Signal read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_tag | output | TAG_W | Slot index of the request |
| rd_req_addr | output | AW | Address of the signal to read |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_tag | input | TAG_W | Slot index of the response |
| rd_rsp_data | input | DW | Signal value returned |
| q_state | output | 2 | Queue condition: 0 open, 1 flag hold, 2 barrier hold |
| all_read | output | 1 | Every read of the current round has returned |
| barrier_done | output | 1 | One-cycle pulse when a barrier is satisfied |
| unblock | output | 1 | One-cycle pulse when a hold ends by completion |

## Verification
The hardest case to reach from the ports is an unmap that lands while reads are still in flight. The bench reaches it by holding back the responses: it lets two of three requests fire, raises unmap in the cycle that would carry the third, and only then returns the two answers one at a time. It checks pkt_ready between the answers. A second awkward case is a response with nothing outstanding. The bench forces a retry with nonzero data and injects a stray answer during the wait, so that a counter that underflows would stall the next round.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
   typedef enum logic [1:0] {
      QS_OPEN         = 2'd0,
      QS_HOLD_FLAG    = 2'd1,
      QS_HOLD_BARRIER = 2'd2
   } qstate_e;

   typedef enum logic {
      PH_ROUND = 1'b0,
      PH_WAIT  = 1'b1
   } phase_e;
endpackage

// File: rtl/bdc_issue.sv
module bdc_issue #(
   parameter int NSIG  = 5,
   parameter int AW    = 32,
   parameter int TAG_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              new_pkt,
   input  logic              restart,
   input  logic              abort,
   input  logic [NSIG-1:0]   mask_in,
   input  logic [NSIG*AW-1:0] addr_in,
   input  logic              req_ready,
   output logic              req_valid,
   output logic [TAG_W-1:0]  req_tag,
   output logic [AW-1:0]     req_addr,
   output logic              idle,
   output logic              fire,
   output logic [NSIG-1:0]   mask_q
);
   logic [NSIG-1:0]    pend_q;
   logic [NSIG*AW-1:0] addr_q;
   logic [TAG_W-1:0]   sel;
   logic               found;

   // lowest pending slot goes first
   always_comb begin
      sel   = '0;
      found = 1'b0;
      for (int i = 0; i < NSIG; i++) begin
         if (pend_q[i] && !found) begin
            sel   = TAG_W'(i);
            found = 1'b1;
         end
      end
   end

   assign req_valid = (|pend_q) && !abort;
   assign req_tag   = sel;
   assign req_addr  = addr_q[int'(sel)*AW +: AW];
   assign fire      = req_valid && req_ready;
   assign idle      = (pend_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= '0;
         mask_q <= '0;
         addr_q <= '0;
      end else if (abort) begin
         pend_q <= '0;
      end else if (new_pkt) begin
         pend_q <= mask_in;
         mask_q <= mask_in;
         addr_q <= addr_in;
      end else if (restart) begin
         pend_q <= mask_q;
      end else if (fire) begin
         pend_q[sel] <= 1'b0;
      end
   end

   assert_pend_in_mask_R4: assert property (@(posedge clk) disable iff (rst)
      (pend_q & ~mask_q) == '0)
      else $error("pending slot outside mask");
endmodule

// File: rtl/bdc_track.sv
module bdc_track #(
   parameter int NSIG  = 5,
   parameter int DW    = 32,
   parameter int TAG_W = 3,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             issue_fire,
   input  logic             rsp_valid,
   input  logic [TAG_W-1:0] rsp_tag,
   input  logic [DW-1:0]    rsp_data,
   input  logic             clear_vals,
   input  logic             unmap,
   input  logic [NSIG-1:0]  mask,
   output logic             cnt_zero,
   output logic             discard,
   output logic             all_zero
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_next;
   logic             take;
   logic             drop_data;
   logic [NSIG-1:0]  slot_ok;

   assign take      = rsp_valid && (cnt_q != '0);
   assign cnt_next  = cnt_q + CNT_W'(issue_fire) - CNT_W'(take);
   assign cnt_zero  = (cnt_q == '0);
   assign drop_data = discard || unmap;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         discard <= 1'b0;
      end else begin
         cnt_q   <= cnt_next;
         discard <= (discard || unmap) && (cnt_next != '0);
      end
   end

   for (genvar g = 0; g < NSIG; g++) begin : g_slot
      logic [DW-1:0] val_q;
      always_ff @(posedge clk) begin
         if (rst || clear_vals) begin
            val_q <= DW'(1);
         end else if (take && !drop_data && rsp_tag == TAG_W'(g)) begin
            val_q <= rsp_data;
         end
      end
      assign slot_ok[g] = !mask[g] || (val_q == '0);
   end

   assign all_zero = &slot_ok;

   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(NSIG))
      else $error("outstanding count beyond slot count");

   assert_discard_pending_R9: assert property (@(posedge clk) disable iff (rst)
      discard |-> !cnt_zero)
      else $error("discard held with nothing outstanding");
endmodule

// File: rtl/bdc_retry.sv
module bdc_retry #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [DLY_W-1:0] delay_in,
   output logic             expired
);
   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= delay_in;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/bdc_gate.sv
module bdc_gate
   import bdc_pkg::*;
#(
   parameter int NSIG  = 5,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DLY_W = 8,
   localparam int TAG_W = (NSIG > 1) ? $clog2(NSIG) : 1,
   localparam int CNT_W = $clog2(NSIG + 1)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               pkt_valid,
   output logic               pkt_ready,
   input  logic               pkt_is_barrier,
   input  logic               pkt_flag,
   input  logic [NSIG-1:0]    pkt_dep_mask,
   input  logic [NSIG*AW-1:0] pkt_dep_addr,
   input  logic               pkt_done,
   input  logic               unmap,
   input  logic [DLY_W-1:0]   retry_delay,
   output logic               rd_req_valid,
   input  logic               rd_req_ready,
   output logic [TAG_W-1:0]   rd_req_tag,
   output logic [AW-1:0]      rd_req_addr,
   input  logic               rd_rsp_valid,
   input  logic [TAG_W-1:0]   rd_rsp_tag,
   input  logic [DW-1:0]      rd_rsp_data,
   output logic [1:0]         q_state,
   output logic               all_read,
   output logic               barrier_done,
   output logic               unblock
);
   if (NSIG < 1 || NSIG > 16) begin : g_bad_nsig
      $error("NSIG must lie in 1..16");
   end
   if (AW < 1 || DW < 1 || DLY_W < 1) begin : g_bad_width
      $error("widths must be positive");
   end

   qstate_e         st_q, st_d;
   phase_e          ph_q, ph_d;
   logic            done_d, unblk_d;
   logic            disp, new_pkt, restart, retry_load, clear_vals;
   logic            issue_idle, issue_fire, cnt_zero, discard, all_zero, expired;
   logic [NSIG-1:0] mask_q;

   assign pkt_ready  = (st_q == QS_OPEN) && !discard && !unmap;
   assign disp       = pkt_valid && pkt_ready;
   assign new_pkt    = disp && pkt_is_barrier;
   assign all_read   = (st_q == QS_HOLD_BARRIER) && (ph_q == PH_ROUND)
                       && issue_idle && cnt_zero;
   assign restart    = (st_q == QS_HOLD_BARRIER) && (ph_q == PH_WAIT)
                       && expired && !unmap;
   assign retry_load = all_read && !all_zero && !unmap;
   assign clear_vals = new_pkt || restart;

   bdc_issue #(.NSIG(NSIG), .AW(AW), .TAG_W(TAG_W)) issue_i (
      .clk       (clk),
      .rst       (rst),
      .new_pkt   (new_pkt),
      .restart   (restart),
      .abort     (unmap),
      .mask_in   (pkt_dep_mask),
      .addr_in   (pkt_dep_addr),
      .req_ready (rd_req_ready),
      .req_valid (rd_req_valid),
      .req_tag   (rd_req_tag),
      .req_addr  (rd_req_addr),
      .idle      (issue_idle),
      .fire      (issue_fire),
      .mask_q    (mask_q)
   );

   bdc_track #(.NSIG(NSIG), .DW(DW), .TAG_W(TAG_W), .CNT_W(CNT_W)) track_i (
      .clk        (clk),
      .rst        (rst),
      .issue_fire (issue_fire),
      .rsp_valid  (rd_rsp_valid),
      .rsp_tag    (rd_rsp_tag),
      .rsp_data   (rd_rsp_data),
      .clear_vals (clear_vals),
      .unmap      (unmap),
      .mask       (mask_q),
      .cnt_zero   (cnt_zero),
      .discard    (discard),
      .all_zero   (all_zero)
   );

   bdc_retry #(.DLY_W(DLY_W)) retry_i (
      .clk      (clk),
      .rst      (rst),
      .load     (retry_load),
      .delay_in (retry_delay),
      .expired  (expired)
   );

   always_comb begin
      st_d    = st_q;
      ph_d    = ph_q;
      done_d  = 1'b0;
      unblk_d = 1'b0;
      case (st_q)
         QS_OPEN: begin
            if (disp) begin
               if (pkt_is_barrier) begin
                  st_d = QS_HOLD_BARRIER;
                  ph_d = PH_ROUND;
               end else if (pkt_flag) begin
                  st_d = QS_HOLD_FLAG;
               end
            end
         end
         QS_HOLD_FLAG: begin
            if (unmap) begin
               st_d = QS_OPEN;
            end else if (pkt_done) begin
               st_d    = QS_OPEN;
               unblk_d = 1'b1;
            end
         end
         QS_HOLD_BARRIER: begin
            if (unmap) begin
               st_d = QS_OPEN;
               ph_d = PH_ROUND;
            end else if (all_read) begin
               if (all_zero) begin
                  st_d    = QS_OPEN;
                  done_d  = 1'b1;
                  unblk_d = 1'b1;
               end else begin
                  ph_d = PH_WAIT;
               end
            end else if (restart) begin
               ph_d = PH_ROUND;
            end
         end
         default: st_d = QS_OPEN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q         <= QS_OPEN;
         ph_q         <= PH_ROUND;
         barrier_done <= 1'b0;
         unblock      <= 1'b0;
      end else begin
         st_q         <= st_d;
         ph_q         <= ph_d;
         barrier_done <= done_d;
         unblock      <= unblk_d;
      end
   end

   assign q_state = st_q;

   assert_ready_open_R2: assert property (@(posedge clk) disable iff (rst)
      pkt_ready |-> q_state == 2'd0)
      else $error("ready outside open state");

   assert_req_in_barrier_R4: assert property (@(posedge clk) disable iff (rst)
      rd_req_valid |-> q_state == 2'd2)
      else $error("read request outside barrier hold");

   assert_flag_holds_R3: assert property (@(posedge clk) disable iff (rst)
      (q_state == 2'd1 && !pkt_done && !unmap) |=> q_state == 2'd1)
      else $error("flag hold released early");

   assert_done_with_unblock_R7: assert property (@(posedge clk) disable iff (rst)
      barrier_done |-> unblock)
      else $error("barrier done without unblock");

   assert_unmap_opens_R9: assert property (@(posedge clk) disable iff (rst)
      unmap |=> (q_state == 2'd0 && !unblock))
      else $error("unmap did not open the queue quietly");

   assert_discard_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      discard |-> (!rd_req_valid && !pkt_ready))
      else $error("activity while draining discarded reads");
endmodule

// File: tb/bdc_gate_tb.sv
module bdc_gate_tb_top;
   localparam int NSIG  = 5;
   localparam int AW    = 32;
   localparam int DW    = 32;
   localparam int DLY_W = 8;
   localparam int TAG_W = 3;
   localparam int NVEC  = 6;
   localparam int RDLY  = 3;
   // each entry: {slot mask, slots answered with zero}
   localparam logic [9:0] VEC [NVEC] = '{
      {5'b11111, 5'b11111},
      {5'b00101, 5'b00101},
      {5'b10010, 5'b00010},
      {5'b00000, 5'b00000},
      {5'b01000, 5'b00000},
      {5'b11011, 5'b11111}
   };

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               pkt_valid = 1'b0;
   logic               pkt_ready;
   logic               pkt_is_barrier = 1'b0;
   logic               pkt_flag = 1'b0;
   logic [NSIG-1:0]    pkt_dep_mask = '0;
   logic [NSIG*AW-1:0] pkt_dep_addr;
   logic               pkt_done = 1'b0;
   logic               unmap = 1'b0;
   logic [DLY_W-1:0]   retry_delay = DLY_W'(RDLY);
   logic               rd_req_valid;
   logic               rd_req_ready = 1'b1;
   logic [TAG_W-1:0]   rd_req_tag;
   logic [AW-1:0]      rd_req_addr;
   logic               rd_rsp_valid = 1'b0;
   logic [TAG_W-1:0]   rd_rsp_tag = '0;
   logic [DW-1:0]      rd_rsp_data = '0;
   logic [1:0]         q_state;
   logic               all_read;
   logic               barrier_done;
   logic               unblock;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   bdc_gate #(.NSIG(NSIG), .AW(AW), .DW(DW), .DLY_W(DLY_W)) dut_i (
      .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
      .pkt_is_barrier(pkt_is_barrier), .pkt_flag(pkt_flag),
      .pkt_dep_mask(pkt_dep_mask), .pkt_dep_addr(pkt_dep_addr),
      .pkt_done(pkt_done), .unmap(unmap), .retry_delay(retry_delay),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_req_tag(rd_req_tag), .rd_req_addr(rd_req_addr),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_tag(rd_rsp_tag),
      .rd_rsp_data(rd_rsp_data), .q_state(q_state), .all_read(all_read),
      .barrier_done(barrier_done), .unblock(unblock)
   );

   function automatic logic [AW-1:0] slot_addr(input int i);
      return 32'h4000_0000 + AW'(i) * 32'h0000_0140 + 32'h8;
   endfunction

   initial begin
      for (int i = 0; i < NSIG; i++) pkt_dep_addr[i*AW +: AW] = slot_addr(i);
   end

   task automatic chk(input logic ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
         finish_run();
      end
   end

   // at a negedge: offer one packet, return at the negedge after acceptance
   task automatic dispatch(input logic barrier, input logic flag, input logic [NSIG-1:0] mask);
      pkt_valid      = 1'b1;
      pkt_is_barrier = barrier;
      pkt_flag       = flag;
      pkt_dep_mask   = mask;
      @(negedge clk);
      pkt_valid      = 1'b0;
      pkt_is_barrier = 1'b0;
      pkt_flag       = 1'b0;
   endtask

   // at a negedge: accept the reads of one round, answer them, end in the all_read cycle
   task automatic serve_round(input logic [NSIG-1:0] mask, input logic [NSIG-1:0] zmask);
      for (int i = 0; i < NSIG; i++) begin
         if (mask[i]) begin
            int t = 0;
            while (!rd_req_valid && t < 40) begin
               @(negedge clk);
               t++;
            end
            chk(rd_req_valid && rd_req_tag == TAG_W'(i), "R4 tag", rd_req_tag, i);
            chk(rd_req_addr == slot_addr(i), "R4 addr", rd_req_addr, slot_addr(i));
            @(negedge clk);
         end
      end
      chk(!rd_req_valid, "R4 no extra read", rd_req_valid, 0);
      for (int i = 0; i < NSIG; i++) begin
         if (mask[i]) begin
            chk(!all_read, "R6 early all_read", all_read, 0);
            rd_rsp_valid = 1'b1;
            rd_rsp_tag   = TAG_W'(i);
            rd_rsp_data  = zmask[i] ? '0 : DW'(7);
            @(negedge clk);
         end
      end
      rd_rsp_valid = 1'b0;
      chk(all_read, "R6 all_read", all_read, 1);
   endtask

   task automatic expect_done();
      @(negedge clk);
      chk(q_state == 2'd0, "R7 state open", q_state, 0);
      chk(barrier_done && unblock, "R7 pulses", {barrier_done, unblock}, 3);
      @(negedge clk);
      chk(!barrier_done && !unblock, "R7 single pulse", {barrier_done, unblock}, 0);
   endtask

   task automatic count_gap(input int exp_gap, input string req);
      int gap = 0;
      @(negedge clk);
      while (!rd_req_valid && gap < 300) begin
         gap++;
         @(negedge clk);
      end
      chk(gap == exp_gap, req, gap, exp_gap);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      chk(q_state == 2'd0 && pkt_ready, "R1 reset open", {q_state, pkt_ready}, 1);
      chk(!rd_req_valid && !all_read && !barrier_done && !unblock, "R1 outputs idle",
          {rd_req_valid, all_read, barrier_done, unblock}, 0);

      // R2: plain packet
      dispatch(1'b0, 1'b0, '0);
      chk(q_state == 2'd0 && pkt_ready, "R2 plain stays open", {q_state, pkt_ready}, 1);

      // table of barrier scenarios
      for (int v = 0; v < NVEC; v++) begin
         logic [NSIG-1:0] m = VEC[v][9:5];
         logic [NSIG-1:0] z = VEC[v][4:0];
         dispatch(1'b1, logic'(v % 2), m);
         chk(q_state == 2'd2 && !pkt_ready, "R4 barrier hold", q_state, 2);
         serve_round(m, z);
         if ((z & m) == m) begin
            expect_done();
         end else begin
            count_gap(RDLY + 1, "R8 retry gap");
            chk(q_state == 2'd2 && !barrier_done, "R8 still held", q_state, 2);
            serve_round(m, '1);
            expect_done();
         end
      end

      // R3: barrier flag hold
      dispatch(1'b0, 1'b1, '0);
      chk(q_state == 2'd1 && !pkt_ready, "R3 flag hold", q_state, 1);
      repeat (3) @(negedge clk);
      chk(q_state == 2'd1, "R3 still held", q_state, 1);
      pkt_done = 1'b1;
      @(negedge clk);
      pkt_done = 1'b0;
      chk(q_state == 2'd0 && unblock, "R3 release", {q_state, unblock}, 1);
      @(negedge clk);
      chk(!unblock, "R3 single unblock", unblock, 0);

      // R10: unmap during flag hold
      dispatch(1'b0, 1'b1, '0);
      unmap = 1'b1;
      @(negedge clk);
      unmap = 1'b0;
      chk(q_state == 2'd0 && !unblock, "R10 quiet open", {q_state, unblock}, 0);

      // R9: unmap with reads in flight
      dispatch(1'b1, 1'b0, 5'b00111);
      @(negedge clk);
      @(negedge clk);
      unmap = 1'b1;
      @(negedge clk);
      unmap = 1'b0;
      chk(q_state == 2'd0 && !pkt_ready && !rd_req_valid, "R9 drain start",
          {q_state, pkt_ready, rd_req_valid}, 0);
      rd_rsp_valid = 1'b1; rd_rsp_tag = 3'd0; rd_rsp_data = '0;
      @(negedge clk);
      chk(!pkt_ready, "R9 still draining", pkt_ready, 0);
      rd_rsp_tag = 3'd1;
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      chk(pkt_ready, "R9 drained", pkt_ready, 1);
      chk(!barrier_done && !unblock && !rd_req_valid, "R9 no pulses",
          {barrier_done, unblock, rd_req_valid}, 0);

      // R5: stray response with nothing outstanding
      retry_delay = DLY_W'(6);
      dispatch(1'b1, 1'b0, 5'b00001);
      serve_round(5'b00001, 5'b00000);
      @(negedge clk);
      rd_rsp_valid = 1'b1; rd_rsp_tag = 3'd0; rd_rsp_data = '0;
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      begin
         int t = 0;
         while (!rd_req_valid && t < 100) begin
            @(negedge clk);
            t++;
         end
         chk(rd_req_valid, "R5 retry after stray", rd_req_valid, 1);
      end
      serve_round(5'b00001, 5'b00001);
      expect_done();
      retry_delay = DLY_W'(RDLY);

      // R1: reset with reads in flight
      dispatch(1'b1, 1'b0, 5'b00011);
      @(negedge clk);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(q_state == 2'd0 && pkt_ready, "R1 mid-read reset", {q_state, pkt_ready}, 1);
      dispatch(1'b1, 1'b0, 5'b00001);
      serve_round(5'b00001, 5'b00001);
      expect_done();

      finish_run();
   end
endmodule